// File: doc/BRIEF.md
# DMA Controller Channel Register Bank

This block is the byte-wide programming interface of a four-channel DMA controller. A host reaches it through a 16-entry synchronous port space with a chip select, a write strobe, a read strobe and an 8-bit data bus. The bank holds, for each channel, a 16-bit start address, a 16-bit transfer count, a mode byte and a mask bit. It also holds a command byte and a status byte. It decodes three commands: master clear, unmask all, and load all masks.

All 16-bit values pass through 8-bit ports. One byte-select toggle is shared by every channel and decides whether an access reaches the low byte or the high byte. Software clears the toggle, then writes or reads the low byte and then the high byte.

The programmed values and the mask vector feed a channel sequencer. The sequencer returns terminal-count pulses and live request lines, and the status port reports both.

Top module: `dmac_regbank`

## Requirements
- R1: After reset all four mask bits are 1, and the command byte, the status flags, the byte-select toggle and every address, count and mode value are 0.
- R2: A port offset below 8 selects channel offset[2:1]; offset[0]=0 selects the address and offset[0]=1 selects the count. Each read or write of such a port reaches the low byte when the toggle is 0 and the high byte when it is 1, then inverts the toggle.
- R3: A write to offset 0xC sets the toggle to 0 whatever the data, so the next 16-bit access reaches the low byte.
- R4: A write to offset 0xA selects a channel with data[1:0] and sets that channel's mask bit to data[2]. The other mask bits do not change.
- R5: A write to offset 0xB selects a channel with data[1:0] and stores data[7:2] as that channel's mode byte, presented with bits 1:0 zero. For example, 0x46 gives channel 2 the mode 0x44, and 0x55 gives channel 1 the mode 0x54 with auto-initialise (bit 4) set.
- R6: A write to offset 0x8 loads the command byte.
- R7: A write to offset 0xF loads all four mask bits from data[3:0]. A write to offset 0xE clears all four mask bits.
- R8: A write to offset 0xD (master clear) sets all mask bits, clears the command byte and the status flags, and sets the toggle to 0. A read of offset 0xD returns 0x00.
- R9: A read of offset 0x8 returns the request lines in bits 7:4 and the sticky terminal-count flags in bits 3:0. Each flag is set by a pulse on its terminal-count input. The read clears the flags after returning them, but a pulse that arrives in the same cycle as the read remains set.
- R10: Read data is valid in the cycle the read strobe is active, and is 0x00 when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 4 | Port offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| tc_i | input | 4 | Terminal-count pulses, one per channel |
| req_i | input | 4 | Live request lines, one per channel |
| base_addr_o | output | 64 | Start addresses, channel n in bits 16n+15:16n |
| base_cnt_o | output | 64 | Transfer counts, channel n in bits 16n+15:16n |
| mode_o | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| mask_o | output | 4 | Mask bits, 1 means masked |
| cmd_o | output | 8 | Command byte |

## Verification
Two events can meet in one cycle: a read of the status port, which clears the terminal-count flags, and a fresh terminal-count pulse from the sequencer. The bench raises a pulse on one channel in exactly the cycle the status read is active. It expects that read to return only the flags that were already set. It then expects the next status read to show the new pulse still held, with the older flags gone.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int NCH     = 4;
    localparam int AW      = 4;
    localparam int DW      = 8;
    localparam int VW      = 16;
    localparam int CHW     = $clog2(NCH);
    localparam int MODE_LO = 2;

    typedef enum logic [AW-1:0] {
        PORT_CMD     = 4'h8,
        PORT_MASK1   = 4'hA,
        PORT_MODE    = 4'hB,
        PORT_PTRCLR  = 4'hC,
        PORT_MCLR    = 4'hD,
        PORT_UNMASK  = 4'hE,
        PORT_MASKALL = 4'hF
    } port_e;

    typedef struct packed {
        logic chan_acc;
        logic wr_cmd;
        logic wr_mask1;
        logic wr_mode;
        logic clr_ptr;
        logic mclr;
        logic unmask_all;
        logic wr_maskall;
        logic rd_status;
    } dec_t;

    function automatic logic [VW-1:0] put_byte(logic [VW-1:0] v, logic hi,
                                               logic [DW-1:0] b);
        logic [VW-1:0] r;
        r = v;
        if (hi) r[VW-1:DW] = b;
        else    r[DW-1:0]  = b;
        return r;
    endfunction

    function automatic logic [DW-1:0] get_byte(logic [VW-1:0] v, logic hi);
        return hi ? v[VW-1:DW] : v[DW-1:0];
    endfunction
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
    import dmac_pkg::*;
(
    input  logic          cs,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    logic w;
    logic r;
    assign w = cs & wr;
    assign r = cs & rd;

    always_comb begin
        dec            = '0;
        dec.chan_acc   = (w | r) & (addr < AW'(2*NCH));
        dec.wr_cmd     = w & (addr == PORT_CMD);
        dec.wr_mask1   = w & (addr == PORT_MASK1);
        dec.wr_mode    = w & (addr == PORT_MODE);
        dec.clr_ptr    = w & (addr == PORT_PTRCLR);
        dec.mclr       = w & (addr == PORT_MCLR);
        dec.unmask_all = w & (addr == PORT_UNMASK);
        dec.wr_maskall = w & (addr == PORT_MASKALL);
        dec.rd_status  = r & (addr == PORT_CMD);
    end
endmodule

// File: rtl/dmac_ptr.sv
module dmac_ptr
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dec_t dec,
    output logic hi_q
);
    always_ff @(posedge clk) begin
        if (rst)                       hi_q <= 1'b0;
        else if (dec.clr_ptr || dec.mclr) hi_q <= 1'b0;
        else if (dec.chan_acc)         hi_q <= ~hi_q;
    end

    p_clear_low_r3: assert property (@(posedge clk) disable iff (rst)
        dec.clr_ptr |=> !hi_q);

    p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (dec.chan_acc && !dec.clr_ptr && !dec.mclr) |=> (hi_q != $past(hi_q)));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          hi,
    output logic [VW-1:0] addr_q,
    output logic [VW-1:0] cnt_q
);
    localparam logic [AW-1:0] A_PORT = AW'(2*IDX);
    localparam logic [AW-1:0] C_PORT = AW'(2*IDX + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_PORT) addr_q <= put_byte(addr_q, hi, wdata);
            if (addr == C_PORT) cnt_q  <= put_byte(cnt_q, hi, wdata);
        end
    end
endmodule

// File: rtl/dmac_status.sv
module dmac_status
    import dmac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  dec_t           dec,
    input  logic [NCH-1:0] tc,
    input  logic [NCH-1:0] req,
    output logic [DW-1:0]  status
);
    logic [NCH-1:0] tc_q;

    always_ff @(posedge clk) begin
        if (rst) tc_q <= '0;
        else     tc_q <= ((dec.rd_status || dec.mclr) ? '0 : tc_q) | tc;
    end

    assign status = {req, tc_q};

    p_tc_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (tc != '0) |=> ((tc_q & $past(tc)) == $past(tc)));

    p_rd_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_status && tc == '0) |=> (tc_q == '0));
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
    import dmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [DW-1:0]      rdata_o,
    input  logic [NCH-1:0]     tc_i,
    input  logic [NCH-1:0]     req_i,
    output logic [NCH*VW-1:0]  base_addr_o,
    output logic [NCH*VW-1:0]  base_cnt_o,
    output logic [NCH*DW-1:0]  mode_o,
    output logic [NCH-1:0]     mask_o,
    output logic [DW-1:0]      cmd_o
);
    localparam int MW = DW - MODE_LO;

    dec_t            dec;
    logic            hi;
    logic [DW-1:0]   status;
    logic [VW-1:0]   a_q [NCH];
    logic [VW-1:0]   c_q [NCH];
    logic [MW-1:0]   mode_q [NCH];
    logic [NCH-1:0]  mask_q;
    logic [DW-1:0]   cmd_q;
    logic [CHW-1:0]  wsel;

    assign wsel = wdata_i[CHW-1:0];

    dmac_decode u_dec (.cs(cs_i), .wr(wr_i), .rd(rd_i), .addr(addr_i), .dec(dec));
    dmac_ptr    u_ptr (.clk(clk), .rst(rst), .dec(dec), .hi_q(hi));
    dmac_status u_st  (.clk(clk), .rst(rst), .dec(dec), .tc(tc_i), .req(req_i),
                       .status(status));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dmac_chan #(.IDX(n)) u_ch (
            .clk(clk), .rst(rst), .wr_en(cs_i & wr_i), .addr(addr_i),
            .wdata(wdata_i), .hi(hi), .addr_q(a_q[n]), .cnt_q(c_q[n]));

        always_ff @(posedge clk) begin
            if (rst)                                  mode_q[n] <= '0;
            else if (dec.wr_mode && wsel == CHW'(n))  mode_q[n] <= wdata_i[DW-1:MODE_LO];
        end

        assign base_addr_o[n*VW +: VW] = a_q[n];
        assign base_cnt_o[n*VW +: VW]  = c_q[n];
        assign mode_o[n*DW +: DW]      = {mode_q[n], {MODE_LO{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            cmd_q  <= '0;
        end else if (dec.mclr) begin
            mask_q <= '1;
            cmd_q  <= '0;
        end else begin
            if (dec.wr_cmd)     cmd_q <= wdata_i;
            if (dec.unmask_all) mask_q <= '0;
            if (dec.wr_maskall) mask_q <= wdata_i[NCH-1:0];
            if (dec.wr_mask1)   mask_q[wsel] <= wdata_i[2];
        end
    end

    assign mask_o = mask_q;
    assign cmd_o  = cmd_q;

    always_comb begin
        rdata_o = '0;
        if (cs_i && rd_i) begin
            if (addr_i < AW'(2*NCH))
                rdata_o = get_byte(addr_i[0] ? c_q[addr_i[CHW:1]] : a_q[addr_i[CHW:1]], hi);
            else if (addr_i == PORT_CMD)
                rdata_o = status;
        end
    end

    p_mask_single_r4: assert property (@(posedge clk) disable iff (rst)
        dec.wr_mask1 |=> (mask_o[$past(wdata_i[CHW-1:0])] == $past(wdata_i[2])));

    p_unmask_all_r7: assert property (@(posedge clk) disable iff (rst)
        dec.unmask_all |=> (mask_o == '0));

    p_mclr_r8: assert property (@(posedge clk) disable iff (rst)
        dec.mclr |=> (mask_o == '1 && cmd_o == '0));

    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        !(cs_i && rd_i) |-> (rdata_o == '0));
endmodule

// File: tb/sim_dmac_regbank.sv
module sim_dmac_regbank;
    logic clk = 0;
    logic rst = 1;
    logic cs = 0, wr = 0, rd = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [3:0] tc = 0, req = 0;
    logic [63:0] base_addr, base_cnt;
    logic [31:0] mode;
    logic [3:0] mask;
    logic [7:0] cmd;

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    dmac_regbank u0 (
        .clk(clk), .rst(rst), .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .tc_i(tc), .req_i(req),
        .base_addr_o(base_addr), .base_cnt_o(base_cnt), .mode_o(mode),
        .mask_o(mask), .cmd_o(cmd));

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (cs && rd) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL read with no expected item: actual %h", rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr_port(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cs = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        cs = 0; wr = 0;
    endtask

    task automatic rd_port(input logic [3:0] a, input logic [7:0] e, input string t,
                           input logic [3:0] tc_same = 4'h0);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        cs = 1; rd = 1; addr = a; tc = tc_same;
        @(posedge clk); #1;
        cs = 0; rd = 0; tc = 0;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string t);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk(mask, 4'hF, "R1 mask");
        chk(cmd, 0, "R1 cmd");
        chk(base_addr, 0, "R1 address");
        chk(mode, 0, "R1 mode");
        rd_port(4'h8, 8'h00, "R1 status");
        // R10 idle read data
        @(negedge clk); chk(rdata, 0, "R10 idle rdata");

        // R2 address of channel 1 at offset 2, count of channel 3 at offset 7
        wr_port(4'h2, 8'h34); wr_port(4'h2, 8'h12);
        chk(base_addr[31:16], 16'h1234, "R2 ch1 address");
        wr_port(4'h7, 8'hFF); wr_port(4'h7, 8'h0F);
        chk(base_cnt[63:48], 16'h0FFF, "R2 ch3 count");
        rd_port(4'h2, 8'h34, "R2 R10 read low");
        rd_port(4'h2, 8'h12, "R2 R10 read high");

        // R3 pointer clear mid-sequence
        wr_port(4'h2, 8'hAA);
        wr_port(4'hC, 8'h5A);
        wr_port(4'h2, 8'h77); wr_port(4'h2, 8'h66);
        chk(base_addr[31:16], 16'h6677, "R3 write after clear");
        rd_port(4'h2, 8'h77, "R3 read low");
        wr_port(4'hC, 8'hFF);
        rd_port(4'h2, 8'h77, "R3 read low again after clear");
        wr_port(4'hC, 8'h00);

        // R4 single mask
        wr_port(4'hA, 8'h01); chk(mask, 4'hD, "R4 unmask ch1");
        wr_port(4'hA, 8'h06); chk(mask, 4'hD, "R4 mask ch2 already set");
        wr_port(4'hA, 8'h02); chk(mask, 4'h9, "R4 unmask ch2");

        // R5 mode
        wr_port(4'hB, 8'h46); chk(mode[23:16], 8'h44, "R5 ch2 mode");
        wr_port(4'hB, 8'h48); chk(mode[7:0],   8'h48, "R5 ch0 mode");
        wr_port(4'hB, 8'hC3); chk(mode[31:24], 8'hC0, "R5 ch3 mode");
        wr_port(4'hB, 8'h55); chk(mode[15:8],  8'h54, "R5 ch1 autoinit");

        // R6 command
        wr_port(4'h8, 8'hA5); chk(cmd, 8'hA5, "R6 cmd");

        // R7 mask all / unmask all
        wr_port(4'hF, 8'hFA); chk(mask, 4'hA, "R7 load all masks");
        wr_port(4'hE, 8'h00); chk(mask, 4'h0, "R7 unmask all");

        // R9 status, and collision of read clear with a new pulse
        req = 4'hC;
        @(posedge clk); #1 tc = 4'h5;
        @(posedge clk); #1 tc = 4'h0;
        rd_port(4'h8, 8'hC5, "R9 status flags");
        rd_port(4'h8, 8'hC0, "R9 flags cleared by read");
        @(posedge clk); #1 tc = 4'h1;
        @(posedge clk); #1 tc = 4'h0;
        rd_port(4'h8, 8'hC1, "R9 collision read returns old flags", 4'h4);
        rd_port(4'h8, 8'hC4, "R9 pulse during read kept");
        rd_port(4'h8, 8'hC0, "R9 cleared after collision");

        // R8 master clear
        @(posedge clk); #1 tc = 4'h8;
        @(posedge clk); #1 tc = 4'h0;
        wr_port(4'h0, 8'h11);
        wr_port(4'hD, 8'h00);
        chk(mask, 4'hF, "R8 masks set");
        chk(cmd, 8'h00, "R8 cmd cleared");
        rd_port(4'h8, 8'hC0, "R8 status cleared");
        rd_port(4'hD, 8'h00, "R8 temp read");
        wr_port(4'h0, 8'h22);
        chk(base_addr[15:0], 16'h0022, "R8 pointer low after clear");

        repeat (2) @(posedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule